// File: doc/BRIEF.md
# Oversampled Serial Receiver with Glitch Rejection

This block receives asynchronous serial characters. A 16x oversampling clock enable paces it, and the block works in the core clock domain. The serial line first passes through a two-flop synchroniser. The receiver then waits for a true high-to-low transition. It confirms that the line is still low half a bit later, then samples eight data bits, an optional parity bit and one stop bit at their centres. A short low pulse that has already ended when it is re-checked is treated as noise. Such a pulse is dropped and produces no character.

For each completed character the block raises a one-cycle write strobe toward a receive FIFO. The strobe carries the data byte and three error flags: parity mismatch, framing error and break. The FIFO storage, the baud-rate divider and the host-side registers live outside this block.

Top module: `async_rx`

## Requirements
- R1: While reset is asserted and after it is released with the line idle high, `push` stays 0.
- R2: The serial input passes through a two-flop synchroniser. A start is detected only on a 16x tick where the synchronised line is 0 and it was 1 at the previous tick.
- R3: At the 8th tick after the detecting tick, the line is sampled. If it is 1, the receiver returns to idle and no write is produced.
- R4: Each following data, parity and stop sample falls 16 ticks after the previous sample. The 8 data bits arrive least significant bit first, so the first data bit lands in `push_data[0]`.
- R5: When `par_en` is 1, one parity bit follows the data. `par_odd` = 0 selects even parity and 1 selects odd parity. `push_perr` is 1 when the data bits and the parity bit together do not have the selected total.
- R6: A stop bit sampled as 0 sets `push_ferr` for that character.
- R7: If all data bits, the parity bit (when enabled) and the stop bit are 0, both `push_brk` and `push_ferr` are 1 and `push_data` is 0. No new start is detected until the line has returned to 1.
- R8: `push` is a one-cycle pulse in the clock cycle after the tick that samples the stop bit. `push_data` and the flags are valid in that same cycle.
- R9: When `par_en` is 0, `push_perr` is 0 and the character ends with the stop bit straight after the eighth data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| par_en | input | 1 | 1 = parity bit present after the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| push | output | 1 | FIFO write strobe, one cycle per character |
| push_data | output | 8 | Received byte |
| push_perr | output | 1 | Parity mismatch for this character |
| push_ferr | output | 1 | Stop bit was 0 |
| push_brk | output | 1 | Whole character, stop bit included, was 0 |

## Verification
The assertions assume that `tick16` arrives no more often than every other clock. They also assume that `par_en` and `par_odd` do not change while a character is being received, and that characters are separated by at least a stop bit's worth of ticks, so two writes never fall on adjacent cycles. The stimulus gives the enable a fixed four-clock spacing and sets the parity controls only between characters while the line idles high. It makes every bit last exactly sixteen ticks, and starts each edge on a clock edge that need not line up with a tick. Noise pulses are three ticks long, well short of the half-bit re-check.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        rx_state_e           state;
        logic [DATA_W-1:0]   shreg;
        logic [2:0]          bitc;
        logic                last;
        logic                pbit;
        logic                push;
        logic [DATA_W-1:0]   data;
        logic                perr;
        logic                ferr;
        logic                brk;
    } rx_regs_t;

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[0] |=> chain_q[1]);
endmodule

// File: rtl/async_rx_timer.sv
module async_rx_timer #(
    parameter int unsigned OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic half,
    output logic hit
);
    localparam int unsigned CW = $clog2(OVS);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign hit = tick && (cnt_q == (half ? HALF_LAST : FULL_LAST));

    always_comb begin
        cnt_d = cnt_q;
        if (restart)   cnt_d = '0;
        else if (hit)  cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    timer_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !restart |=> $stable(cnt_q));
endmodule

// File: rtl/async_rx.sv
module async_rx #(
    parameter int unsigned OVS       = 16,
    parameter int unsigned SYNC_STGS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       push,
    output logic [7:0] push_data,
    output logic       push_perr,
    output logic       push_ferr,
    output logic       push_brk
);
    import async_rx_pkg::*;

    localparam logic [2:0] LAST_BIT = 3'(DATA_W - 1);

    logic     rx_s;
    logic     hit;
    logic     restart;
    logic     half;
    rx_regs_t r_d, r_q;

    async_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    async_rx_timer #(.OVS(OVS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick16),
        .restart(restart),
        .half   (half),
        .hit    (hit)
    );

    always_comb begin
        r_d     = r_q;
        r_d.push = 1'b0;
        restart = 1'b0;
        half    = (r_q.state == RX_START);
        if (tick16) r_d.last = rx_s;
        unique case (r_q.state)
            RX_IDLE: begin
                if (tick16 && r_q.last && !rx_s) begin
                    r_d.state = RX_START;
                    restart   = 1'b1;
                end
            end
            RX_START: begin
                if (hit) begin
                    if (!rx_s) begin
                        r_d.state = RX_DATA;
                        r_d.bitc  = '0;
                        r_d.pbit  = 1'b0;
                    end else begin
                        r_d.state = RX_IDLE;
                    end
                end
            end
            RX_DATA: begin
                if (hit) begin
                    r_d.shreg = {rx_s, r_q.shreg[DATA_W-1:1]};
                    r_d.bitc  = r_q.bitc + 1'b1;
                    if (r_q.bitc == LAST_BIT)
                        r_d.state = par_en ? RX_PAR : RX_STOP;
                end
            end
            RX_PAR: begin
                if (hit) begin
                    r_d.pbit  = rx_s;
                    r_d.state = RX_STOP;
                end
            end
            RX_STOP: begin
                if (hit) begin
                    r_d.push  = 1'b1;
                    r_d.data  = r_q.shreg;
                    r_d.perr  = par_en && ((^r_q.shreg) ^ r_q.pbit ^ par_odd);
                    r_d.ferr  = !rx_s;
                    r_d.brk   = !rx_s && (r_q.shreg == '0) && (!par_en || !r_q.pbit);
                    r_d.state = RX_IDLE;
                end
            end
            default: r_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= RX_IDLE;
            r_q.last  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign push      = r_q.push;
    assign push_data = r_q.data;
    assign push_perr = r_q.perr;
    assign push_ferr = r_q.ferr;
    assign push_brk  = r_q.brk;

    // R8
    push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    // R8
    push_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push) |-> $past(tick16));

    // R7
    brk_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && push_brk |-> push_ferr && (push_data == '0));

    // R3
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == RX_START) && hit && rx_s |=> (r_q.state == RX_IDLE) && !push);

    // R9
    noparity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !par_en |-> !push_perr);
endmodule

// File: tb/tb_async_rx.sv
module tb_async_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
        logic       bk;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       push;
    logic [7:0] push_data;
    logic       push_perr, push_ferr, push_brk;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   writes = 0;
    int   pushed = 0;
    bit   done = 0;

    async_rx dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .push(push),
        .push_data(push_data), .push_perr(push_perr),
        .push_ferr(push_ferr), .push_brk(push_brk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            tick16 = (c == TICK_DIV - 1);
            c = (c == TICK_DIV - 1) ? 0 : c + 1;
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && push) begin
            writes++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3: unexpected write data=%02h, expected none", push_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (push_data !== e.d || push_perr !== e.pe || push_ferr !== e.fe || push_brk !== e.bk) begin
                    errors++;
                    $display("FAIL %s: got d=%02h pe=%b fe=%b bk=%b, expected d=%02h pe=%b fe=%b bk=%b",
                             e.tag, push_data, push_perr, push_ferr, push_brk, e.d, e.pe, e.fe, e.bk);
                end
            end
        end
    end

    task automatic idle_bits(input int n);
        repeat (n * BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic pen, input logic podd,
                             input logic bad_par, input logic stop_val,
                             input int extra_low, input string tag);
        exp_t e;
        logic pbit;
        par_en  = pen;
        par_odd = podd;
        pbit = (^d) ^ podd ^ bad_par;
        e.d   = d;
        e.pe  = pen && bad_par;
        e.fe  = !stop_val;
        e.bk  = !stop_val && (d == 8'h00) && (!pen || !pbit);
        e.tag = tag;
        exp_q.push_back(e);
        pushed++;
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        if (pen) begin
            rxd = pbit;
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = stop_val;
        repeat (BIT_CLKS) @(negedge clk);
        repeat (extra_low * BIT_CLKS) @(negedge clk);
        rxd = 1'b1;
        idle_bits(2);
    endtask

    task automatic check_count(input string tag);
        checks++;
        if (writes != pushed) begin
            errors++;
            $display("FAIL %s: write count %0d, expected %0d", tag, writes, pushed);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        checks++;
        if (push !== 1'b0) begin
            errors++;
            $display("FAIL R1: push=%b during reset, expected 0", push);
        end
        rst_n = 1'b1;
        idle_bits(1);
        checks++;
        if (push !== 1'b0 || writes != 0) begin
            errors++;
            $display("FAIL R1: push=%b writes=%0d after reset, expected 0/0", push, writes);
        end

        // R4 R9: plain characters, LSB first, no parity
        send_char(8'hA5, 0, 0, 0, 1, 0, "R4");
        send_char(8'h01, 0, 0, 0, 1, 0, "R4");
        send_char(8'h80, 0, 0, 0, 1, 0, "R9");
        send_char(8'hFF, 0, 0, 0, 1, 0, "R9");

        // R5: parity good and bad, even and odd
        send_char(8'h3C, 1, 0, 0, 1, 0, "R5");
        send_char(8'h07, 1, 1, 0, 1, 0, "R5");
        send_char(8'h07, 1, 0, 1, 1, 0, "R5");
        send_char(8'hC1, 1, 1, 1, 1, 0, "R5");

        // R6: framing error, data nonzero
        send_char(8'h5A, 0, 0, 0, 0, 0, "R6");

        // R3 R2: short glitch rejected
        @(negedge clk);
        rxd = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        idle_bits(2);
        check_count("R3");
        send_char(8'h96, 0, 0, 0, 1, 0, "R3");

        // R7: break, line held low afterwards yields no second character
        send_char(8'h00, 0, 0, 0, 0, 3, "R7");
        check_count("R7");
        send_char(8'h00, 1, 0, 0, 0, 0, "R7");
        send_char(8'h42, 0, 0, 0, 1, 0, "R7");

        // R8: zero data with good stop is not a break
        send_char(8'h00, 0, 0, 0, 1, 0, "R8");

        idle_bits(2);
        check_count("R8");
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: %0d characters missing, expected 0", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule